// File: doc/BRIEF.md
# Gated Power-of-Two Clock Divider

This block divides a free-running master clock by a programmable power of two, 2^x with x from 0 to 8, and presents the result as a gated output clock. An output-enable input starts and stops the output cleanly. A power-down input, filtered so that short pulses are ignored, halts the divider. The divided clock is registered, so every pulse it puts out is whole, and enabling from the idle state always gives the same number of master cycles to the first rising edge.

After reset the output is held off for a fixed number of master cycles, 512 by default. An 8-bit control word carries the exponent in its low four bits and a disabled-state select in bit 5. The block does not drive a pad. A separate drive-enable output tells the pad whether to drive the stopped clock low or leave it high-impedance while the divider is halted by power-down or by the start-up hold-off.

Top module: `pow2_gated_clkdiv`

## Requirements
- R1: For exponent x from 1 to 8 (control bits [3:0]) the output is high for exactly 2^(x-1) master cycles and low for exactly 2^(x-1) master cycles, a ratio of 2^x at 50% duty.
- R2: After reset is released the output stays low for the first 512 master rising edges. With enable high and x=1, it first rises on edge 513. During reset, with bit 5 at 0, drive_en_o is 0.
- R3: Every output pulse is complete. When enable falls during a high phase, that phase still lasts its full 2^(x-1) cycles before the output goes low.
- R4: From the idle state, the output first rises on the 2^(x-1)-th master rising edge at which enable is sampled high. This delay is the same every time for a given x.
- R5: A power-down pulse held for fewer than 2·2^x + DEGLITCH master edges (DEGLITCH defaults to 16) has no effect. The output keeps toggling and drive_en_o stays 1.
- R6: Once power-down takes effect, the output is low and drive_en_o equals control bit 5: 1 means drive low, 0 means high-impedance.
- R7: When power-down is released, the divider restarts from zero. With enable high, the first rising edge comes 2^(x-1)+1 master edges after the release.
- R8: Exponent codes 9 to 15 act as 8, giving a ratio of 256.
- R9: With x=0 and enable high, the output follows the master clock through a gate that is updated only while the master clock is low.
- R10: While enable is low and power-down is inactive, the output stays low and drive_en_o stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| oe_i | input | 1 | Output enable, synchronous to clk_i |
| pdn_i | input | 1 | Power-down request, filtered |
| ctrl_i | input | 8 | [3:0] exponent, [5] disabled-state select (1 = drive low, 0 = high-Z) |
| clk_o | output | 1 | Gated divided clock |
| drive_en_o | output | 1 | Pad drive enable for clk_o |

## Verification
The power-down filter and the divider's phase counter both advance on the same master edges. A power-down pulse one edge shorter than the filter threshold therefore lands while the divided clock is mid-toggle. The bench applies such a pulse with the output running at ratio 2 and checks that no sample shows the drive enable dropping and that the output keeps alternating every edge. Enable removal and a high-phase terminal count are also made to coincide: enable is dropped on the cycle right after a rising edge, and the bench judges the result by the length of that last high phase.

// File: rtl/pow2_clkdiv_pkg.sv
`timescale 1ns/1ps
package pow2_clkdiv_pkg;
   localparam int CTRL_W     = 8;
   localparam int EXP_FIELD  = 4;
   localparam int LOSEL_BIT  = 5;

   typedef logic [EXP_FIELD-1:0] exp_t;

   function automatic exp_t clamp_exp(input exp_t raw, input int max_exp);
      exp_t lim;
      lim = exp_t'(max_exp);
      return (raw > lim) ? lim : raw;
   endfunction
endpackage

// File: rtl/pow2_startup_hold.sv
`timescale 1ns/1ps
module pow2_startup_hold #(
   parameter int CYCLES = 512
) (
   input  logic clk_i,
   input  logic rst_ni,
   output logic done_o
);
   generate
      if (CYCLES == 0) begin : g_none
         assign done_o = 1'b1;
      end else begin : g_count
         localparam int SW = $clog2(CYCLES + 1);
         localparam logic [SW-1:0] LAST = SW'(CYCLES);
         logic [SW-1:0] cnt_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)           cnt_q <= '0;
            else if (cnt_q != LAST) cnt_q <= cnt_q + SW'(1);
         end
         assign done_o = (cnt_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/pow2_pdn_filter.sv
`timescale 1ns/1ps
module pow2_pdn_filter
   import pow2_clkdiv_pkg::*;
#(
   parameter int MAX_EXP  = 8,
   parameter int DEGLITCH = 16
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic pdn_i,
   input  exp_t exp_i,
   output logic pdn_act_o
);
   localparam int LW = $clog2((2 << MAX_EXP) + DEGLITCH + 1);

   logic [LW-1:0] limit;
   logic [LW-1:0] pcnt_q;

   // threshold: two output periods plus the deglitch window
   assign limit = (LW'(2) << exp_i) + LW'(DEGLITCH);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            pcnt_q <= '0;
      else if (!pdn_i)        pcnt_q <= '0;
      else if (pcnt_q < limit) pcnt_q <= pcnt_q + LW'(1);
   end

   assign pdn_act_o = (pcnt_q >= limit);
endmodule

// File: rtl/pow2_div_core.sv
`timescale 1ns/1ps
module pow2_div_core
   import pow2_clkdiv_pkg::*;
#(
   parameter int MAX_EXP = 8
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               run_i,
   input  logic               oe_i,
   input  exp_t               exp_i,
   output logic               div_o,
   output logic [MAX_EXP-1:0] cnt_o
);
   localparam int CW = MAX_EXP;

   logic [CW:0]   full;
   logic [CW-1:0] last;
   logic [CW-1:0] cnt_q;
   logic          div_q;
   logic          idle;

   assign full = (CW+1)'(1) << exp_i;
   assign last = CW'((full >> 1) - (CW+1)'(1));
   // parked: low, counter at zero, nobody asking for a clock
   assign idle = !div_q && (cnt_q == '0) && !oe_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         div_q <= 1'b0;
      end else if (!run_i) begin
         cnt_q <= '0;
         div_q <= 1'b0;
      end else if (idle) begin
         cnt_q <= '0;
      end else if (cnt_q == last) begin
         cnt_q <= '0;
         div_q <= ~div_q;
      end else begin
         cnt_q <= cnt_q + CW'(1);
      end
   end

   assign div_o = div_q;
   assign cnt_o = cnt_q;
endmodule

// File: rtl/pow2_bypass_gate.sv
`timescale 1ns/1ps
module pow2_bypass_gate (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_i,
   output logic clk_o
);
   logic gate_q;
   // updated on the falling edge only, so the AND never clips a high phase
   always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) gate_q <= 1'b0;
      else         gate_q <= en_i;
   end
   assign clk_o = clk_i & gate_q;
endmodule

// File: rtl/pow2_gated_clkdiv.sv
`timescale 1ns/1ps
module pow2_gated_clkdiv
   import pow2_clkdiv_pkg::*;
#(
   parameter int MAX_EXP        = 8,
   parameter int STARTUP_CYCLES = 512,
   parameter int DEGLITCH       = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              oe_i,
   input  logic              pdn_i,
   input  logic [CTRL_W-1:0] ctrl_i,
   output logic              clk_o,
   output logic              drive_en_o
);
   generate
      if (MAX_EXP < 1 || MAX_EXP > 15) begin : g_bad_exp
         $error("MAX_EXP must lie in 1..15");
      end
      if (DEGLITCH < 0) begin : g_bad_dg
         $error("DEGLITCH must not be negative");
      end
      if (STARTUP_CYCLES < 0) begin : g_bad_st
         $error("STARTUP_CYCLES must not be negative");
      end
   endgenerate

   exp_t               exp_eff;
   logic               lo_drive;
   logic               start_done;
   logic               pdn_act;
   logic               run;
   logic               bypass;
   logic               div_q;
   logic [MAX_EXP-1:0] cnt_q;
   logic               byp_clk;
   logic               unused_ctrl;

   assign exp_eff     = clamp_exp(ctrl_i[EXP_FIELD-1:0], MAX_EXP);
   assign lo_drive    = ctrl_i[LOSEL_BIT];
   assign unused_ctrl = ^{ctrl_i[7:6], ctrl_i[4]};
   assign bypass      = (exp_eff == '0);
   assign run         = start_done && !pdn_act;

   pow2_startup_hold #(.CYCLES(STARTUP_CYCLES)) u_hold (
      .clk_i(clk_i), .rst_ni(rst_ni), .done_o(start_done));

   pow2_pdn_filter #(.MAX_EXP(MAX_EXP), .DEGLITCH(DEGLITCH)) u_pdn (
      .clk_i(clk_i), .rst_ni(rst_ni), .pdn_i(pdn_i),
      .exp_i(exp_eff), .pdn_act_o(pdn_act));

   pow2_div_core #(.MAX_EXP(MAX_EXP)) u_core (
      .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run && !bypass),
      .oe_i(oe_i), .exp_i(exp_eff), .div_o(div_q), .cnt_o(cnt_q));

   pow2_bypass_gate u_byp (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .en_i(run && bypass && oe_i), .clk_o(byp_clk));

   assign clk_o      = bypass ? byp_clk : div_q;
   assign drive_en_o = run || lo_drive;
endmodule

// File: rtl/pow2_gated_clkdiv_chk.sv
`timescale 1ns/1ps
module pow2_gated_clkdiv_chk #(
   parameter int MAX_EXP = 8
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               pdn_i,
   input logic               clk_o,
   input logic               drive_en_o,
   input logic               start_done,
   input logic               pdn_act,
   input logic               bypass,
   input logic               lo_drive,
   input logic               div_q,
   input logic [MAX_EXP-1:0] cnt_q
);
   assert_hold_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !start_done |-> !clk_o);

   assert_no_runt_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!bypass && !$past(bypass) && !$stable(div_q)) |-> (cnt_q == '0));

   assert_short_pdn_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pdn_act |-> $past(pdn_i));

   assert_pdn_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pdn_act |=> !div_q);

   assert_hiz_select_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(drive_en_o) |-> !lo_drive);
endmodule

bind pow2_gated_clkdiv pow2_gated_clkdiv_chk #(.MAX_EXP(MAX_EXP)) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .pdn_i(pdn_i), .clk_o(clk_o),
   .drive_en_o(drive_en_o), .start_done(start_done), .pdn_act(pdn_act),
   .bypass(bypass), .lo_drive(lo_drive), .div_q(div_q), .cnt_q(cnt_q));

// File: tb/pow2_gated_clkdiv_bench.sv
`timescale 1ns/1ps
module pow2_gated_clkdiv_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       oe = 1'b1;
   logic       pdn = 1'b0;
   logic [7:0] ctrl = 8'h01;
   logic       clk_o;
   logic       drive_en;
   int         errors = 0;
   int         checks = 0;

   always #2 clk = ~clk;

   pow2_gated_clkdiv u_pow2_gated_clkdiv (
      .clk_i(clk), .rst_ni(rst_n), .oe_i(oe), .pdn_i(pdn),
      .ctrl_i(ctrl), .clk_o(clk_o), .drive_en_o(drive_en));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step();     @(posedge clk); #1; endtask
   task automatic nstep();    @(negedge clk); #1; endtask
   task automatic steps(input int n); for (int i = 0; i < n; i++) step(); endtask

   task automatic wait_rise(output int n);
      logic prev;
      n = 0; prev = clk_o;
      do begin prev = clk_o; step(); n++; end
      while (!(clk_o && !prev) && n < 2000);
   endtask

   task automatic measure(output int hi, output int lo);
      int n;
      wait_rise(n);
      hi = 1; step();
      while (clk_o && hi < 600) begin hi++; step(); end
      lo = 1; step();
      while (!clk_o && lo < 600) begin lo++; step(); end
   endtask

   task automatic park(input logic [7:0] c);
      nstep(); oe = 1'b0; ctrl = c;
      steps(600);
   endtask

   task automatic t_reset_startup();
      int n;
      bit low_ok = 1;
      steps(3);
      check(clk_o == 1'b0, "R2 reset clk_o", clk_o, 0);
      check(drive_en == 1'b0, "R2 reset drive_en (bit5=0)", drive_en, 0);
      nstep(); rst_n = 1'b1;
      for (n = 1; n <= 512; n++) begin
         step();
         if (clk_o) low_ok = 0;
      end
      check(low_ok, "R2 low through edge 512", low_ok, 1);
      step();
      check(clk_o == 1'b1, "R2 first rise at edge 513", clk_o, 1);
   endtask

   task automatic t_ratio(input logic [7:0] c, input int half, input string req);
      int hi, lo;
      park(c);
      nstep(); oe = 1'b1;
      measure(hi, lo);
      check(hi == half, {req, " high phase"}, hi, half);
      check(lo == half, {req, " low phase"}, lo, half);
   endtask

   task automatic t_latency(input logic [7:0] c, input int half);
      int n;
      for (int rep = 0; rep < 2; rep++) begin
         park(c);
         nstep(); oe = 1'b1;
         n = 0;
         do begin step(); n++; end while (!clk_o && n < 600);
         check(n == half, "R4 enable-to-first-rise", n, half);
      end
   endtask

   task automatic t_disable_mid_high();
      int n, hi;
      bit quiet = 1, drv = 1;
      park(8'h03);
      nstep(); oe = 1'b1;
      wait_rise(n);
      nstep(); oe = 1'b0;
      hi = 1;
      while (clk_o && hi < 600) begin step(); if (clk_o) hi++; end
      check(hi == 4, "R3 last high phase full length", hi, 4);
      for (int i = 0; i < 32; i++) begin
         step();
         if (clk_o) quiet = 0;
         if (!drive_en) drv = 0;
      end
      check(quiet, "R10 output low while disabled", quiet, 1);
      check(drv, "R10 drive_en high while disabled", drv, 1);
   endtask

   task automatic t_short_pdn();
      int toggles = 0;
      bit drv = 1;
      logic prev;
      park(8'h01);
      nstep(); oe = 1'b1;
      steps(4);
      nstep(); pdn = 1'b1;
      prev = clk_o;
      for (int i = 0; i < 19; i++) begin
         step();
         if (clk_o != prev) toggles++;
         prev = clk_o;
         if (!drive_en) drv = 0;
      end
      nstep(); pdn = 1'b0;
      for (int i = 0; i < 8; i++) begin
         step();
         if (clk_o != prev) toggles++;
         prev = clk_o;
         if (!drive_en) drv = 0;
      end
      check(toggles >= 26, "R5 short pdn keeps output toggling", toggles, 27);
      check(drv, "R5 short pdn keeps drive_en", drv, 1);
   endtask

   task automatic t_long_pdn();
      int n;
      park(8'h21);
      nstep(); oe = 1'b1;
      steps(4);
      nstep(); pdn = 1'b1;
      steps(26);
      check(clk_o == 1'b0, "R6 output low in power-down", clk_o, 0);
      check(drive_en == 1'b1, "R6 drive low when bit5=1", drive_en, 1);
      nstep(); ctrl = 8'h01;
      step();
      check(drive_en == 1'b0, "R6 high-Z when bit5=0", drive_en, 0);
      nstep(); pdn = 1'b0;
      n = 0;
      do begin step(); n++; end while (!clk_o && n < 600);
      check(n == 2, "R7 restart after power-down", n, 2);
   endtask

   task automatic t_bypass();
      bit hi_ok = 1, lo_ok = 1;
      park(8'h00);
      nstep(); oe = 1'b1;
      steps(3);
      for (int i = 0; i < 6; i++) begin
         step();  if (clk_o !== 1'b1) hi_ok = 0;
         nstep(); if (clk_o !== 1'b0) lo_ok = 0;
      end
      check(hi_ok, "R9 follows master high", hi_ok, 1);
      check(lo_ok, "R9 follows master low", lo_ok, 1);
   endtask

   initial begin
      #(4 * 190000);
      errors++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      t_reset_startup();
      t_ratio(8'h01, 1,   "R1 x=1");
      t_ratio(8'h03, 4,   "R1 x=3");
      t_ratio(8'h05, 16,  "R1 x=5");
      t_ratio(8'h08, 128, "R1 x=8");
      t_ratio(8'h0C, 128, "R8 code 12 clamps to 8");
      t_latency(8'h02, 2);
      t_latency(8'h06, 32);
      t_disable_mid_high();
      t_short_pdn();
      t_long_pdn();
      t_bypass();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule